// File: doc/BRIEF.md
# Memory-Reference Effective Address Generator

This block turns one memory-reference instruction of a 16-bit accumulator machine into its operand address. The instruction is an 8-bit opcode with an octal layout and an 8-bit displacement. With the opcode the caller presents the current program counter and the contents of accumulators two and three, and pulses `start`. The block decodes the instruction class and the accumulator number, picks one of four address bases, and adds the displacement to it. If the opcode asks for indirection it makes one read on a request/valid memory port. The word returned by that read is the final address.

Each instruction ends with exactly one of two one-cycle pulses. `done` comes with the final address on `ea`. `illegal` comes when the opcode lies outside the memory-reference range. The class, accumulator and indirect outputs keep their values until the next instruction is accepted. While an indirect read is outstanding, `busy` is high and new `start` pulses are ignored. In the cycle that `done` is high, a new instruction may already be started.

Top module: `ea_gen`

## Requirements
- R1: After reset, `mem_req`, `done`, `illegal` and `busy` are low, and `ea` and `mem_addr` are zero.
- R2: `iclass` decodes the opcode by octal range: 000–007 gives 0 (jump) and 010–017 gives 1 (subroutine call). 020–027 gives 2 (increment and skip) and 030–037 gives 3 (decrement and skip). 040–077 gives 4 (load) and 100–137 gives 5 (store). Any illegal opcode gives 7. The value is visible from the cycle after `start` is accepted.
- R3: `acsel` equals opcode bits 4:3 for load and store. It is 0 for the other four classes and for illegal opcodes.
- R4: When opcode bits 1:0 are 0 (page zero), the address is the displacement, zero-extended to 16 bits.
- R5: When opcode bits 1:0 are 1, the address is `pc` plus the displacement, sign-extended from bit 7. The sum wraps modulo 2^16.
- R6: When opcode bits 1:0 are 2 or 3, the address is `ac2` or `ac3` respectively, plus the sign-extended displacement. The sum wraps modulo 2^16.
- R7: When opcode bit 2 is 1 on a legal opcode, `indirect` is 1. The block then raises `mem_req` with `mem_addr` set to the address of R4–R6, and holds both until the cycle in which `mem_valid` is high. It makes exactly one such read per instruction. In every other case `indirect` is 0 and no read is made.
- R8: For a direct opcode, `done` is high for one cycle, in the cycle after `start` is accepted, with `ea` set to the R4–R6 address. For an indirect opcode, `done` is high in the cycle after the one in which `mem_valid` is sampled, with `ea` set to the `mem_data` of that cycle.
- R9: An opcode of 0140 octal or above raises `illegal` for one cycle, in the cycle after `start`. No `done` and no memory request follow. `done` and `illegal` are never high together.
- R10: A `start` sampled while `busy` is high is ignored: `mem_addr`, the final `ea` and the handshake count are unaffected.
- R11: A `start` sampled in the cycle where `done` is high is accepted, so instructions can follow each other without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one instruction (accepted when `busy` is low) |
| opcode | input | 8 | Instruction opcode byte |
| disp | input | 8 | Displacement byte |
| pc | input | 16 | Current program counter |
| ac2 | input | 16 | Accumulator two contents |
| ac3 | input | 16 | Accumulator three contents |
| mem_req | output | 1 | Indirect read request, held until `mem_valid` |
| mem_addr | output | 16 | Address of the indirect read |
| mem_valid | input | 1 | Read data valid; completes the request |
| mem_data | input | 16 | Read data |
| busy | output | 1 | An indirect read is outstanding |
| done | output | 1 | One-cycle pulse: `ea` holds the final address |
| illegal | output | 1 | One-cycle pulse: opcode outside the legal range |
| ea | output | 16 | Effective address |
| iclass | output | 3 | Instruction class code |
| acsel | output | 2 | Accumulator selector |
| indirect | output | 1 | Instruction uses one-level indirection |

## Verification
Two events can fall in the same cycle: the completion pulse of one instruction and the acceptance of the next. A related collision is a `start` that arrives while a read is outstanding. The bench holds `start` high through the `done` cycle, for both a direct and an indirect follower. It then checks that the second `done` comes one cycle later with the new address, or that a fresh request appears at the new address. For the collision, it pulses `start` in the middle of a pending read. It checks that the request address does not move, that only one handshake happens, and that the final address is the returned word.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int OP_W = 8;

    typedef enum logic [2:0] {
        CL_JMP  = 3'd0,
        CL_JSR  = 3'd1,
        CL_ISZ  = 3'd2,
        CL_DSZ  = 3'd3,
        CL_LDA  = 3'd4,
        CL_STA  = 3'd5,
        CL_NONE = 3'd7
    } op_class_e;

    typedef enum logic [1:0] {
        BASE_ZERO = 2'd0,
        BASE_PC   = 2'd1,
        BASE_AC2  = 2'd2,
        BASE_AC3  = 2'd3
    } base_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } fetch_state_e;

    typedef struct packed {
        op_class_e   cls;
        logic [1:0]  acc;
        logic        ind;
        base_e       base;
        logic        bad;
    } dec_t;

    // Class of a legal opcode from its top five bits
    function automatic op_class_e class_of(input logic [OP_W-1:0] op);
        op_class_e c;
        unique case (op[7:5])
            3'b000: begin
                case (op[4:3])
                    2'b00:   c = CL_JMP;
                    2'b01:   c = CL_JSR;
                    2'b10:   c = CL_ISZ;
                    default: c = CL_DSZ;
                endcase
            end
            3'b001:  c = CL_LDA;
            3'b010:  c = CL_STA;
            default: c = CL_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ea_decode.sv
module ea_decode
    import ea_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output dec_t            dec
);
    op_class_e cls;
    logic      bad;

    always_comb begin
        cls = class_of(op);
        bad = (cls == CL_NONE);
    end

    always_comb begin
        dec.cls  = cls;
        dec.bad  = bad;
        dec.base = base_e'(op[1:0]);
        dec.ind  = op[2] & ~bad;
        dec.acc  = ((cls == CL_LDA) || (cls == CL_STA)) ? op[4:3] : 2'b00;
    end
endmodule

// File: rtl/ea_addr.sv
module ea_addr
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  base_e           base,
    input  logic [DW-1:0]   disp,
    input  logic [AW-1:0]   pc,
    input  logic [AW-1:0]   ac2,
    input  logic [AW-1:0]   ac3,
    output logic [AW-1:0]   addr
);
    localparam int EXT = AW - DW;

    logic [AW-1:0] disp_z;
    logic [AW-1:0] disp_s;
    logic [AW-1:0] base_v;

    generate
        if (EXT > 0) begin : g_ext
            assign disp_z = {{EXT{1'b0}}, disp};
            assign disp_s = {{EXT{disp[DW-1]}}, disp};
        end else begin : g_trunc
            assign disp_z = disp[AW-1:0];
            assign disp_s = disp[AW-1:0];
        end
    endgenerate

    always_comb begin
        unique case (base)
            BASE_PC:  base_v = pc;
            BASE_AC2: base_v = ac2;
            BASE_AC3: base_v = ac3;
            default:  base_v = '0;
        endcase
    end

    always_comb begin
        if (base == BASE_ZERO) addr = disp_z;
        else                   addr = base_v + disp_s;
    end
endmodule

// File: rtl/ea_fetch.sv
module ea_fetch
    import ea_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic          launch_ind,
    input  logic          launch_bad,
    input  logic [AW-1:0] launch_addr,
    input  logic          mem_valid,
    input  logic [AW-1:0] mem_data,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          done,
    output logic          illegal,
    output logic [AW-1:0] ea,
    output logic          busy
);
    fetch_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            mem_req  <= 1'b0;
            mem_addr <= '0;
            done     <= 1'b0;
            illegal  <= 1'b0;
            ea       <= '0;
        end else begin
            done    <= 1'b0;
            illegal <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (launch) begin
                        if (launch_bad) begin
                            illegal <= 1'b1;
                        end else if (launch_ind) begin
                            state    <= ST_WAIT;
                            mem_req  <= 1'b1;
                            mem_addr <= launch_addr;
                        end else begin
                            done <= 1'b1;
                            ea   <= launch_addr;
                        end
                    end
                end
                ST_WAIT: begin
                    if (mem_valid) begin
                        state   <= ST_IDLE;
                        mem_req <= 1'b0;
                        done    <= 1'b1;
                        ea      <= mem_data;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state == ST_WAIT);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [OP_W-1:0] opcode,
    input  logic [DW-1:0]   disp,
    input  logic [AW-1:0]   pc,
    input  logic [AW-1:0]   ac2,
    input  logic [AW-1:0]   ac3,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_valid,
    input  logic [AW-1:0]   mem_data,
    output logic            busy,
    output logic            done,
    output logic            illegal,
    output logic [AW-1:0]   ea,
    output logic [2:0]      iclass,
    output logic [1:0]      acsel,
    output logic            indirect
);
    dec_t          dec;
    logic [AW-1:0] raw_addr;
    logic          accept;
    dec_t          dec_q;

    ea_decode u_dec (
        .op  (opcode),
        .dec (dec)
    );

    ea_addr #(.AW(AW), .DW(DW)) u_addr (
        .base (dec.base),
        .disp (disp),
        .pc   (pc),
        .ac2  (ac2),
        .ac3  (ac3),
        .addr (raw_addr)
    );

    assign accept = start & ~busy;

    ea_fetch #(.AW(AW)) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .launch      (accept),
        .launch_ind  (dec.ind),
        .launch_bad  (dec.bad),
        .launch_addr (raw_addr),
        .mem_valid   (mem_valid),
        .mem_data    (mem_data),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .done        (done),
        .illegal     (illegal),
        .ea          (ea),
        .busy        (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '{cls: CL_NONE, acc: 2'b00, ind: 1'b0, base: BASE_ZERO, bad: 1'b0};
        end else if (accept) begin
            dec_q <= dec;
        end
    end

    assign iclass   = dec_q.cls;
    assign acsel    = dec_q.acc;
    assign indirect = dec_q.ind;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [7:0]    opcode,
    input logic [DW-1:0] disp,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] ac2,
    input logic [AW-1:0] ac3,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_valid,
    input logic [AW-1:0] mem_data,
    input logic          busy,
    input logic          done,
    input logic          illegal,
    input logic [AW-1:0] ea,
    input logic [2:0]    iclass,
    input logic [1:0]    acsel,
    input logic          indirect
);
    logic legal_op;
    assign legal_op = (opcode < 8'o140);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr)); // R7

    AST_REQ_DONE: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_valid |=> !mem_req && done && (ea == $past(mem_data))); // R8

    AST_DIRECT_DONE: assert property (@(posedge clk) disable iff (rst)
        start && !busy && legal_op && !opcode[2] |=> done && !mem_req); // R8

    AST_IND_REQ: assert property (@(posedge clk) disable iff (rst)
        start && !busy && legal_op && opcode[2] |=> mem_req && !done && indirect); // R7

    AST_ILL_PULSE: assert property (@(posedge clk) disable iff (rst)
        start && !busy && !legal_op |=> illegal && !done && !mem_req && (iclass == 3'd7)); // R9

    AST_DONE_ILL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && illegal)); // R9

    AST_ACSEL_ZERO: assert property (@(posedge clk) disable iff (rst)
        done && (iclass < 3'd4) |-> acsel == 2'b00); // R3

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        start && mem_req && !mem_valid |=> mem_req && $stable(mem_addr) && !done); // R10
endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/ea_gen_test.sv
`timescale 1ns/1ps
module ea_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  disp = '0;
    logic [15:0] pc = '0;
    logic [15:0] ac2 = '0;
    logic [15:0] ac3 = '0;
    logic        mem_valid = 1'b0;
    logic [15:0] mem_data = '0;
    logic        mem_req, busy, done, illegal, indirect;
    logic [15:0] mem_addr, ea;
    logic [2:0]  iclass;
    logic [1:0]  acsel;

    int checks = 0;
    int failures = 0;
    int hs_seen = 0;
    int hs_exp = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ea_gen uut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .disp(disp),
        .pc(pc), .ac2(ac2), .ac3(ac3), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_data(mem_data), .busy(busy), .done(done),
        .illegal(illegal), .ea(ea), .iclass(iclass), .acsel(acsel),
        .indirect(indirect)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // handshake counter and per-clock exclusivity check
    always @(posedge clk) if (!rst && mem_req && mem_valid) hs_seen++;
    always @(negedge clk) if (!rst) chk(!(done && illegal), "R9 done/illegal overlap", int'(done), 0);

    function automatic int ref_class(input int op);
        if (op < 'o10)  return 0;
        if (op < 'o20)  return 1;
        if (op < 'o30)  return 2;
        if (op < 'o40)  return 3;
        if (op < 'o100) return 4;
        if (op < 'o140) return 5;
        return 7;
    endfunction

    function automatic int ref_acc(input int op);
        int c = ref_class(op);
        if (c == 4 || c == 5) return (op / 8) % 4;
        return 0;
    endfunction

    function automatic int ref_addr(input int op, input int d);
        int m = op % 4;
        int sd = (d > 127) ? d - 256 : d;
        int b;
        if (m == 0) return d;
        b = (m == 1) ? int'(pc) : (m == 2) ? int'(ac2) : int'(ac3);
        return (b + sd + 65536) % 65536;
    endfunction

    // Launch one instruction and follow it to its end.
    task automatic run_op(input int op, input int d, input int lat, input int mdat, input string tag);
        int exp_a = ref_addr(op, d);
        bit ind = ((op / 4) % 2 == 1);
        opcode = 8'(op); disp = 8'(d); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(int'(iclass) == ref_class(op), {"R2 class ", tag}, iclass, ref_class(op));
        chk(int'(acsel) == ref_acc(op), {"R3 acsel ", tag}, acsel, ref_acc(op));
        if (op >= 'o140) begin
            chk(illegal && !done && !mem_req, "R9 illegal pulse", {illegal, done, mem_req}, 3'b100);
            @(negedge clk);
            chk(!illegal && !done && !mem_req, "R9 no follow-up", {illegal, done, mem_req}, 0);
        end else if (!ind) begin
            chk(done && !mem_req && !indirect, "R8 direct done", {done, mem_req, indirect}, 3'b100);
            chk(int'(ea) == exp_a, {"R4 R5 R6 direct ea ", tag}, ea, exp_a);
            @(negedge clk);
            chk(!done, "R8 done one cycle", done, 0);
        end else begin
            hs_exp++;
            chk(mem_req && !done && indirect, "R7 request raised", {mem_req, done, indirect}, 3'b101);
            chk(int'(mem_addr) == exp_a, {"R7 R4 R5 R6 request addr ", tag}, mem_addr, exp_a);
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                chk(mem_req && !done && int'(mem_addr) == exp_a, "R7 request held", mem_addr, exp_a);
            end
            mem_valid = 1'b1; mem_data = 16'(mdat);
            @(negedge clk);
            mem_valid = 1'b0;
            chk(done && !mem_req, "R8 indirect done", {done, mem_req}, 2'b10);
            chk(int'(ea) == mdat, "R7 ea from memory", ea, mdat);
            @(negedge clk);
            chk(!done && !mem_req, "R7 single read", {done, mem_req}, 0);
        end
    endtask

    initial begin
        pc = 16'h1234; ac2 = 16'h8000; ac3 = 16'hFFF0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_req && !done && !illegal && !busy, "R1 reset outputs", {mem_req, done, illegal, busy}, 0);
        chk(ea == 16'h0 && mem_addr == 16'h0, "R1 reset ea", ea, 0);

        // sweep of all legal opcodes
        for (int op = 0; op < 'o140; op++) begin
            pc  = 16'(16'h1234 + op * 3);
            ac2 = 16'(16'h8000 - op);
            ac3 = 16'hFFF0;
            run_op(op, (op * 37 + 5) % 256, op % 3, (op * 613 + 17) % 65536, "sweep");
        end

        // displacement sign edges
        pc = 16'h0010; ac2 = 16'h0005; ac3 = 16'hFFFF;
        run_op('o040, 8'h80, 0, 0, "R4 page zero 0x80");
        run_op('o041, 8'h80, 0, 0, "R5 pc minus 128");
        run_op('o041, 8'h7F, 0, 0, "R5 pc plus 127");
        run_op('o042, 8'hF0, 0, 0, "R6 ac2 wrap below zero");
        run_op('o073, 8'h01, 0, 0, "R6 ac3 wrap past top");
        run_op('o127, 8'hFE, 2, 16'hBEEF, "R6 R7 store ac3 indirect");

        // illegal opcodes
        run_op('o140, 8'h10, 0, 0, "R9 first illegal");
        run_op('o377, 8'h10, 0, 0, "R9 last illegal");
        run_op('o200, 8'h10, 0, 0, "R9 mid illegal");

        // R10: start during pending read is ignored
        pc = 16'h2000;
        opcode = 8'o045; disp = 8'h04; start = 1'b1;
        @(negedge clk);
        hs_exp++;
        opcode = 8'o000; disp = 8'h55; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(mem_req && mem_addr == 16'h2004 && !done, "R10 addr kept", mem_addr, 16'h2004);
        mem_valid = 1'b1; mem_data = 16'h0ACE;
        @(negedge clk);
        mem_valid = 1'b0;
        chk(done && ea == 16'h0ACE, "R10 ea from read", ea, 16'h0ACE);
        chk(iclass == 3'd4, "R10 class kept", iclass, 4);
        @(negedge clk);
        chk(!done && !mem_req && ea == 16'h0ACE, "R10 ignored start left no trace", ea, 16'h0ACE);

        // R11: back-to-back in the done cycle
        opcode = 8'o020; disp = 8'h11; start = 1'b1;
        @(negedge clk);
        chk(done && ea == 16'h0011, "R11 first done", ea, 16'h0011);
        opcode = 8'o130; disp = 8'h22;
        @(negedge clk);
        chk(done && ea == 16'h0022, "R11 second done", ea, 16'h0022);
        chk(iclass == 3'd5 && acsel == 2'd3, "R11 second class", {iclass, acsel}, 5'b10111);
        opcode = 8'o066; disp = 8'h03; ac2 = 16'h0100;
        @(negedge clk);
        start = 1'b0;
        hs_exp++;
        chk(mem_req && mem_addr == 16'h0103 && !done, "R11 indirect follower", mem_addr, 16'h0103);
        mem_valid = 1'b1; mem_data = 16'h7777;
        @(negedge clk);
        mem_valid = 1'b0;
        chk(done && ea == 16'h7777 && acsel == 2'd2, "R11 follower done", ea, 16'h7777);
        @(negedge clk);

        chk(hs_seen == hs_exp, "R7 handshake count", hs_seen, hs_exp);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(500_000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule